// File: doc/BRIEF.md
# USB Endpoint Router with Data-Toggle Tracking

This block decides which device endpoint an incoming USB token addresses and keeps the DATA0/DATA1 sequence bit for each endpoint. It serves five endpoints. The control endpoint always uses number 0, and its current data direction is set by firmware. Four general endpoints each have a programmable number, a direction, an enable, a toggle mode and a maximum packet size. When a token arrives, the router reports which endpoints match and which one it selected. It also reports the PID the next data packet should carry, and it flags a received byte count that is larger than the selected endpoint's packet limit.

The protocol engine uses the block in three steps. It presents the token. It then reports the received byte count of an OUT data packet. Finally it strobes transaction completion with a success flag. The completion strobe updates the selected endpoint's toggle. Packet decoding, CRC, FIFO storage and request handling sit outside the block.

Top module: `usb_ep_router`

## Requirements
- R1: The control endpoint (hit bit 0, index 0) matches a token whose number is 0 and whose direction equals `ctl_dir_in`. A SETUP token on number 0 matches it whatever the direction.
- R2: General endpoint g (hit bit g+1, index g+1) matches a non-SETUP token when it is enabled, its 4-bit number field `gen_num[4g+3:4g]` equals the token number and its direction bit equals the token direction. Token number 0 and SETUP tokens never match a general endpoint.
- R3: A general endpoint whose enable bit is 0 never sets its hit bit.
- R4: When several general endpoints match, the one with the lowest index is selected and `conflict` is 1. Otherwise `conflict` is 0.
- R5: `hit`, `sel_idx`, `sel_valid` and `conflict` update on the clock edge that samples `tok_valid` and hold until the next token. With no match, `sel_valid`=0 and `sel_idx`=0.
- R6: `exp_data1` reports the selected endpoint's toggle at token time (1 = DATA1). It is 0 when nothing matched.
- R7: Toggle mode 0 (and the control endpoint always) flips the toggle on a completion only if `xfer_ok`=1 and no overflow was flagged.
- R8: Toggle mode 1 flips the toggle on every completion, whatever the outcome.
- R9: A byte count above the selected endpoint's limit sets `ovf_err` one cycle later, and it stays set until the next token. The limit is 8 << `ctl_mps` for the control endpoint (codes 0..3 give 8, 16, 32, 64 bytes) and the 11-bit field `gen_mps[11g+10:11g]` for general endpoint g.
- R10: A completion following a SETUP token selected on the control endpoint sets its toggle to DATA1, whatever the outcome.
- R11: Reset and `bus_reset` clear every toggle to DATA0. A rising enable bit clears that general endpoint's toggle. After reset all outputs are 0.
- R12: A completion strobe while `sel_valid`=0 changes no toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token strobe |
| tok_num | input | 4 | Token endpoint number |
| tok_in | input | 1 | Token direction, 1 = IN |
| tok_setup | input | 1 | Token is SETUP |
| ctl_dir_in | input | 1 | Control endpoint data direction, 1 = IN |
| ctl_mps | input | 2 | Control endpoint size code |
| gen_en | input | 4 | General endpoint enables |
| gen_dir_in | input | 4 | General endpoint directions, 1 = IN |
| gen_num | input | 16 | General endpoint numbers, 4 bits each |
| gen_tmode | input | 4 | Toggle modes, 1 = every transaction |
| gen_mps | input | 44 | Packet limits, 11 bits each |
| rx_count_valid | input | 1 | Received byte count strobe |
| rx_count | input | 11 | Received byte count |
| xfer_done | input | 1 | Transaction completion strobe |
| xfer_ok | input | 1 | Transaction succeeded |
| bus_reset | input | 1 | USB bus reset |
| hit | output | 5 | Matching endpoints, bit 0 = control |
| sel_idx | output | 3 | Selected endpoint index |
| sel_valid | output | 1 | An endpoint was selected |
| conflict | output | 1 | Several general endpoints matched |
| exp_data1 | output | 1 | Expected PID, 1 = DATA1 |
| ovf_err | output | 1 | Byte count above limit |

## Verification
The bench aims at two general endpoints that share a number and direction. A router that picked the wrong one, or that hid the conflict, would route data to the wrong endpoint. It sends SETUP tokens that are opposite to the control direction; a router that dropped them would leave the control pipe deaf to SETUP. It checks byte counts one byte above and at each limit; an off-by-one compare would reject full packets or accept oversized ones, and an overflow that did not fail the transaction would advance a mode-0 toggle. Failed transactions in both toggle modes, enable edges and bus resets show whether a toggle moves when it should not or keeps a stale value.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {
    CTL_MPS_8  = 2'd0,
    CTL_MPS_16 = 2'd1,
    CTL_MPS_32 = 2'd2,
    CTL_MPS_64 = 2'd3
  } ctl_mps_e;

  function automatic int unsigned ctl_limit(input logic [1:0] code);
    return 32'd8 << code;
  endfunction
endpackage

// File: rtl/ep_match.sv
module ep_match #(
  parameter int NGEN  = 4,
  parameter int NUM_W = 4,
  parameter int IDX_W = $clog2(NGEN + 1)
) (
  input  logic [NUM_W-1:0]      tok_num,
  input  logic                  tok_in,
  input  logic                  tok_setup,
  input  logic                  ctl_dir_in,
  input  logic [NGEN-1:0]       gen_en,
  input  logic [NGEN-1:0]       gen_dir_in,
  input  logic [NGEN*NUM_W-1:0] gen_num,
  output logic [NGEN:0]         raw_hit,
  output logic [IDX_W-1:0]      win_idx,
  output logic                  win_valid,
  output logic                  multi
);
  logic tok_zero;
  assign tok_zero   = (tok_num == '0);
  assign raw_hit[0] = tok_zero && (tok_setup || (tok_in == ctl_dir_in));

  for (genvar g = 0; g < NGEN; g++) begin : g_cmp
    assign raw_hit[g+1] = gen_en[g] && !tok_setup && !tok_zero &&
                          (gen_dir_in[g] == tok_in) &&
                          (gen_num[g*NUM_W +: NUM_W] == tok_num);
  end

  always_comb begin
    int unsigned cnt;
    win_idx   = '0;
    win_valid = |raw_hit;
    cnt       = 0;
    for (int i = NGEN; i >= 0; i--) begin
      if (raw_hit[i]) win_idx = IDX_W'(i);
    end
    for (int i = 1; i <= NGEN; i++) begin
      if (raw_hit[i]) cnt++;
    end
    multi = (cnt > 1);
  end
endmodule

// File: rtl/ep_size_check.sv
module ep_size_check
  import usb_ep_pkg::*;
#(
  parameter int NGEN  = 4,
  parameter int MPS_W = 11,
  parameter int IDX_W = $clog2(NGEN + 1)
) (
  input  logic [1:0]            ctl_mps,
  input  logic [NGEN*MPS_W-1:0] gen_mps,
  input  logic [IDX_W-1:0]      idx,
  input  logic [MPS_W-1:0]      count,
  output logic                  over
);
  logic [(NGEN+1)*MPS_W-1:0] limits;
  logic [MPS_W-1:0]          lim;

  assign limits = {gen_mps, MPS_W'(ctl_limit(ctl_mps))};
  assign lim    = limits[idx*MPS_W +: MPS_W];
  assign over   = (count > lim);
endmodule

// File: rtl/ep_toggle_bank.sv
module ep_toggle_bank #(
  parameter int NEP   = 5,
  parameter int IDX_W = $clog2(NEP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset,
  input  logic [NEP-1:0]   clr,
  input  logic             upd,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_flip,
  input  logic             upd_set1,
  output logic [NEP-1:0]   tog
);
  for (genvar e = 0; e < NEP; e++) begin : g_ep
    always_ff @(posedge clk) begin
      if (rst || bus_reset) begin
        tog[e] <= 1'b0;
      end else if (clr[e]) begin
        tog[e] <= 1'b0;
      end else if (upd && (upd_idx == IDX_W'(e))) begin
        if (upd_set1)      tog[e] <= 1'b1;
        else if (upd_flip) tog[e] <= ~tog[e];
      end
    end
  end
endmodule

// File: rtl/usb_ep_router.sv
module usb_ep_router #(
  parameter int NGEN  = 4,
  parameter int NUM_W = 4,
  parameter int MPS_W = 11,
  parameter int IDX_W = $clog2(NGEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tok_valid,
  input  logic [NUM_W-1:0]      tok_num,
  input  logic                  tok_in,
  input  logic                  tok_setup,
  input  logic                  ctl_dir_in,
  input  logic [1:0]            ctl_mps,
  input  logic [NGEN-1:0]       gen_en,
  input  logic [NGEN-1:0]       gen_dir_in,
  input  logic [NGEN*NUM_W-1:0] gen_num,
  input  logic [NGEN-1:0]       gen_tmode,
  input  logic [NGEN*MPS_W-1:0] gen_mps,
  input  logic                  rx_count_valid,
  input  logic [MPS_W-1:0]      rx_count,
  input  logic                  xfer_done,
  input  logic                  xfer_ok,
  input  logic                  bus_reset,
  output logic [NGEN:0]         hit,
  output logic [IDX_W-1:0]      sel_idx,
  output logic                  sel_valid,
  output logic                  conflict,
  output logic                  exp_data1,
  output logic                  ovf_err
);
  localparam int NEP = NGEN + 1;

  logic [NGEN:0]      raw_hit;
  logic [IDX_W-1:0]   win_idx;
  logic               win_valid, multi, over;
  logic [NEP-1:0]     tog_q;
  logic [NGEN-1:0]    en_q;
  logic               setup_q;
  logic [NEP-1:0]     tmode_all;
  logic [NEP-1:0]     clr;
  logic               upd, flip, set1;

  ep_match #(.NGEN(NGEN), .NUM_W(NUM_W), .IDX_W(IDX_W)) u_match (
    .tok_num(tok_num), .tok_in(tok_in), .tok_setup(tok_setup),
    .ctl_dir_in(ctl_dir_in), .gen_en(gen_en), .gen_dir_in(gen_dir_in),
    .gen_num(gen_num), .raw_hit(raw_hit), .win_idx(win_idx),
    .win_valid(win_valid), .multi(multi)
  );

  ep_size_check #(.NGEN(NGEN), .MPS_W(MPS_W), .IDX_W(IDX_W)) u_size (
    .ctl_mps(ctl_mps), .gen_mps(gen_mps), .idx(sel_idx),
    .count(rx_count), .over(over)
  );

  assign tmode_all = {gen_tmode, 1'b0};
  assign clr       = {gen_en & ~en_q, 1'b0};
  assign upd       = xfer_done && sel_valid;
  assign set1      = setup_q && (sel_idx == '0);
  assign flip      = tmode_all[sel_idx] || (xfer_ok && !ovf_err);

  ep_toggle_bank #(.NEP(NEP), .IDX_W(IDX_W)) u_tog (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .clr(clr),
    .upd(upd), .upd_idx(sel_idx), .upd_flip(flip), .upd_set1(set1),
    .tog(tog_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= '0;
      sel_idx   <= '0;
      sel_valid <= 1'b0;
      conflict  <= 1'b0;
      exp_data1 <= 1'b0;
      setup_q   <= 1'b0;
      ovf_err   <= 1'b0;
      en_q      <= '0;
    end else begin
      en_q <= gen_en;
      if (tok_valid) begin
        hit       <= raw_hit;
        sel_idx   <= win_idx;
        sel_valid <= win_valid;
        conflict  <= multi;
        exp_data1 <= win_valid && tog_q[win_idx];
        setup_q   <= tok_setup && win_valid && (win_idx == '0);
        ovf_err   <= 1'b0;
      end else if (rx_count_valid && sel_valid && over) begin
        ovf_err   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_ep_router_chk.sv
module usb_ep_router_chk #(
  parameter int NGEN  = 4,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tok_valid,
  input logic [NGEN-1:0]  gen_en,
  input logic             bus_reset,
  input logic             rx_count_valid,
  input logic             xfer_done,
  input logic [NGEN:0]    hit,
  input logic [IDX_W-1:0] sel_idx,
  input logic             sel_valid,
  input logic             conflict,
  input logic             ovf_err,
  input logic [NGEN:0]    tog,
  input logic             setup
);
  assert_sel_in_hit_R5: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> hit[sel_idx]);

  assert_conflict_multi_R4: assert property (@(posedge clk) disable iff (rst)
    conflict |-> ($countones(hit[NGEN:1]) > 1));

  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (rst)
    $past(tok_valid) |-> ((hit[NGEN:1] & ~$past(gen_en)) == '0));

  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(rx_count_valid));

  assert_busreset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(bus_reset) |-> (tog == '0));

  assert_setup_data1_R10: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_done && sel_valid && (sel_idx == '0) && setup && !bus_reset)
      |-> tog[0]);
endmodule

bind usb_ep_router usb_ep_router_chk #(.NGEN(NGEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .tok_valid(tok_valid), .gen_en(gen_en),
  .bus_reset(bus_reset), .rx_count_valid(rx_count_valid),
  .xfer_done(xfer_done), .hit(hit), .sel_idx(sel_idx),
  .sel_valid(sel_valid), .conflict(conflict), .ovf_err(ovf_err),
  .tog(tog_q), .setup(setup_q)
);

// File: tb/usb_ep_router_test.sv
module usb_ep_router_test;
  localparam int NGEN = 4, NUM_W = 4, MPS_W = 11, IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_valid = 0, tok_in = 0, tok_setup = 0, ctl_dir_in = 0;
  logic [NUM_W-1:0] tok_num = '0;
  logic [1:0] ctl_mps = '0;
  logic [NGEN-1:0] gen_en = '0, gen_dir_in = '0, gen_tmode = '0;
  logic [NGEN*NUM_W-1:0] gen_num = '0;
  logic [NGEN*MPS_W-1:0] gen_mps = '0;
  logic rx_count_valid = 0, xfer_done = 0, xfer_ok = 0, bus_reset = 0;
  logic [MPS_W-1:0] rx_count = '0;
  logic [NGEN:0] hit;
  logic [IDX_W-1:0] sel_idx;
  logic sel_valid, conflict, exp_data1, ovf_err;

  int n_chk = 0, n_fail = 0;
  logic [NGEN:0] m_tog = '0;
  logic [NGEN:0] m_hit;
  int m_sel;
  logic m_valid = 0, m_setup = 0, m_ovf = 0;

  always #10 clk = ~clk;

  usb_ep_router #(.NGEN(NGEN), .NUM_W(NUM_W), .MPS_W(MPS_W)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int idx);
    if (idx == 0) return 8 << ctl_mps;
    return int'(gen_mps[(idx-1)*MPS_W +: MPS_W]);
  endfunction

  task automatic token(input int num, input logic din, input logic stp, input string tag);
    @(negedge clk);
    tok_valid = 1; tok_num = NUM_W'(num); tok_in = din; tok_setup = stp;
    m_hit[0] = (num == 0) && (stp || din == ctl_dir_in);
    for (int g = 0; g < NGEN; g++)
      m_hit[g+1] = gen_en[g] && !stp && num != 0 && gen_dir_in[g] == din &&
                   int'(gen_num[g*NUM_W +: NUM_W]) == num;
    m_valid = |m_hit; m_sel = 0;
    for (int i = NGEN; i >= 0; i--) if (m_hit[i]) m_sel = i;
    m_setup = stp && m_valid && m_sel == 0;
    m_ovf = 0;
    @(negedge clk);
    tok_valid = 0; tok_setup = 0;
    chk(tag, hit, m_hit);
    chk("R5 sel_valid", sel_valid, m_valid);
    chk("R5 sel_idx", sel_idx, m_sel);
    chk("R4 conflict", conflict, $countones(m_hit[NGEN:1]) > 1);
    chk("R6 exp_data1", exp_data1, m_valid && m_tog[m_sel]);
  endtask

  task automatic count(input int c);
    @(negedge clk);
    rx_count_valid = 1; rx_count = MPS_W'(c);
    if (m_valid && c > lim_of(m_sel)) m_ovf = 1;
    @(negedge clk);
    rx_count_valid = 0;
    chk("R9 ovf_err", ovf_err, m_ovf);
  endtask

  task automatic done(input logic ok);
    @(negedge clk);
    xfer_done = 1; xfer_ok = ok;
    if (m_valid) begin
      if (m_setup) m_tog[0] = 1;                                   // R10
      else if ((m_sel > 0 && gen_tmode[m_sel-1]) || (ok && !m_ovf)) // R7 R8
        m_tog[m_sel] = ~m_tog[m_sel];
    end                                                            // R12
    @(negedge clk);
    xfer_done = 0;
  endtask

  task automatic set_en(input logic [NGEN-1:0] e);
    @(negedge clk);
    for (int g = 0; g < NGEN; g++) if (e[g] && !gen_en[g]) m_tog[g+1] = 0; // R11
    gen_en = e;
    @(negedge clk);
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    m_tog = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset hit", {hit, sel_idx, sel_valid, conflict, exp_data1, ovf_err}, 0);

    // a: ep1 OUT mode0 64; b: ep1 OUT mode1 32; c: ep2 IN mode0 10; d: ep3 IN disabled
    gen_num = {4'd3, 4'd2, 4'd1, 4'd1};
    gen_dir_in = 4'b1100; gen_tmode = 4'b0010;
    gen_mps = {11'd20, 11'd10, 11'd32, 11'd64};
    ctl_dir_in = 0; ctl_mps = 2'd1;
    set_en(4'b0111);
    token(1, 0, 0, "R4 R2 shared number");
    token(3, 1, 0, "R3 disabled");
    token(0, 0, 0, "R1 ctl dir match");
    token(0, 1, 0, "R1 ctl dir mismatch");
    token(0, 1, 1, "R1 setup");
    count(16); count(17);
    done(0);
    token(0, 0, 0, "R10 after setup");
    token(2, 1, 0, "R2 ep c");
    count(11);          // R9 one above limit
    done(1);            // R7 overflow blocks flip
    token(2, 1, 0, "R7 no flip");
    count(10);
    done(1);
    token(2, 1, 0, "R7 flip");
    set_en(4'b0110);
    token(1, 0, 0, "R2 b alone");
    done(0);            // R8 mode 1 flips on failure
    token(1, 0, 0, "R8 flipped");
    token(5, 1, 0, "R12 no hit");
    done(1);            // R12 ignored
    token(2, 1, 0, "R12 c unchanged");
    breset();
    token(2, 1, 0, "R11 bus reset");
    token(1, 0, 0, "R11 bus reset b");

    for (int it = 0; it < 400; it++) begin
      if ($urandom % 4 == 0) begin
        for (int g = 0; g < NGEN; g++) begin
          gen_num[g*NUM_W +: NUM_W] = NUM_W'(1 + $urandom % 3);
          gen_dir_in[g] = 1'($urandom);
          gen_tmode[g] = 1'($urandom);
          gen_mps[g*MPS_W +: MPS_W] = MPS_W'(1 + $urandom % 1024);
        end
        ctl_dir_in = 1'($urandom); ctl_mps = 2'($urandom);
        set_en(4'($urandom));
      end
      if ($urandom % 25 == 0) breset();
      begin
        int n = $urandom % 4;
        logic s = ($urandom % 6 == 0);
        token(n, 1'($urandom), s, "R2 random");
      end
      if ($urandom % 2 == 0) begin
        int base = m_valid ? lim_of(m_sel) : 40;
        int c = base + int'($urandom % 3) - 1;
        count(c);
      end
      done(1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule